// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator

This block counts transitions on an asynchronous input line into an 8-bit counter that software can read and overwrite at any time. The counter deliberately keeps its contents across reset. Only one transition direction is counted, chosen by a polarity input. Two sticky status flags record that a counted edge arrived and that the counter wrapped from 0xFF to 0x00. Each flag has an enable bit in a companion mask register. An interrupt output is asserted while a flag and its enable are both set.

Software talks to the block over a byte-wide register bus. Each write is a single-cycle strobe with address and data, and read data is a combinational function of the address. Flags are cleared by writing ones into a status register, so that each flag can be acknowledged without disturbing the other. The input line passes through a two-stage synchroniser before edge detection. As a result, a counted edge shows up in the counter on the third rising clock edge after the input changes.

Top module: `pulse_accum`

## Requirements
- R1: The counter is read and written at offset 0x27, and a write is visible on the next read.
- R2: The counter keeps its value through reset. After reset, the mask register at 0x24 and the status register at 0x25 read 0x00.
- R3: Each selected edge on `accumPin` adds exactly one to the counter, modulo 256. If the pin changes before rising clock edge N, the counter changes at edge N+2.
- R4: With `edgeFallSel`=0 only low-to-high transitions count. With `edgeFallSel`=1 only high-to-low transitions count. The other direction leaves the counter and the flags untouched.
- R5: Status bit 5 (wrap flag) is set when an increment takes the counter from 0xFF to 0x00.
- R6: Status bit 4 (edge flag) is set in the same cycle that a selected edge increments the counter.
- R7: Writing 0x25 with a 1 in bit 5 or bit 4 clears that flag. A 0 in that bit leaves the flag unchanged.
- R8: If a flag is set by hardware and cleared by software in the same cycle, the flag ends up set.
- R9: A counter write in the same cycle as an increment loads the written value, and the wrap flag is not set in that cycle.
- R10: The mask register stores bits 7, 6, 5, 4, 1 and 0, and bits 3 and 2 read 0. In the status register, bits 7, 6 and 3..0 read 0.
- R11: `paOvfIrq` equals wrap flag AND mask bit 5, and `paEdgeIrq` equals edge flag AND mask bit 4. The enable bits never change how the flags are set or cleared.
- R12: Any other address reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (does not touch the counter) |
| regAddr | input | 8 | Register offset |
| regWe | input | 1 | Single-cycle write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| accumPin | input | 1 | Asynchronous event input |
| edgeFallSel | input | 1 | 0 counts rising edges, 1 counts falling edges |
| paOvfIrq | output | 1 | Wrap interrupt request |
| paEdgeIrq | output | 1 | Edge interrupt request |

## Verification
The assertions check the following on every clock:
- a counter write lands exactly as written;
- an increment adds one;
- a wrap always leaves the wrap flag set;
- a hardware set survives a simultaneous clear;
- a counter write never raises the wrap flag.

Other behaviour only shows up in the bench's scenarios, because it depends on the pin-to-counter latency across the synchroniser or on reset:
- ignoring the unselected edge direction;
- the masking of interrupts;
- counter retention through reset;
- reads of reserved bits and unmapped addresses.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef struct packed {
    logic cntWr;
    logic cntInc;
    logic maskWr;
    logic flagWr;
  } paStrobe_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_FLAG,
    SEL_CNT
  } paRdSel_t;

  localparam int OVF_BIT  = 5;
  localparam int EDGE_BIT = 4;

endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 8'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              accumPin,
  input  logic              edgeFallSel,
  output paStrobe_t         strb,
  output paRdSel_t          rdSel
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevPin;
  logic                   syncPin;
  logic                   edgeHit;

  assign syncPin = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevPin <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], accumPin};
      prevPin <= syncPin;
    end
  end

  always_comb begin
    if (edgeFallSel) edgeHit = prevPin & ~syncPin;
    else             edgeHit = syncPin & ~prevPin;
  end

  always_comb begin
    strb.cntInc = edgeHit;
    strb.cntWr  = regWe && (regAddr == CNT_ADDR);
    strb.maskWr = regWe && (regAddr == MASK_ADDR);
    strb.flagWr = regWe && (regAddr == FLAG_ADDR);
  end

  always_comb begin
    if      (regAddr == MASK_ADDR) rdSel = SEL_MASK;
    else if (regAddr == FLAG_ADDR) rdSel = SEL_FLAG;
    else if (regAddr == CNT_ADDR)  rdSel = SEL_CNT;
    else                           rdSel = SEL_NONE;
  end

  // R4: a counted edge needs a real transition of the synchronised line
  assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntInc |-> (syncPin != prevPin));

endmodule

// File: rtl/pa_data.sv
module pa_data
  import pa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  paStrobe_t         strb,
  input  paRdSel_t          rdSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              paOvfIrq,
  output logic              paEdgeIrq
);

  localparam logic [DATA_W-1:0] MASK_KEEP = DATA_W'(8'hF3);

  logic [DATA_W-1:0] cntReg;
  logic [DATA_W-1:0] maskReg;
  logic              ovfFlag;
  logic              edgeFlag;
  logic              wrapNow;
  logic              clrOvf;
  logic              clrEdge;

  assign wrapNow = strb.cntInc && !strb.cntWr && (cntReg == '1);
  assign clrOvf  = strb.flagWr && regWdata[OVF_BIT];
  assign clrEdge = strb.flagWr && regWdata[EDGE_BIT];

  // counter: deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (strb.cntWr)       cntReg <= regWdata;
    else if (strb.cntInc) cntReg <= cntReg + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '0;
      ovfFlag  <= 1'b0;
      edgeFlag <= 1'b0;
    end else begin
      if (strb.maskWr) maskReg <= regWdata & MASK_KEEP;
      ovfFlag  <= (ovfFlag  & ~clrOvf)  | wrapNow;
      edgeFlag <= (edgeFlag & ~clrEdge) | strb.cntInc;
    end
  end

  always_comb begin
    regRdata = '0;
    case (rdSel)
      SEL_MASK: regRdata = maskReg;
      SEL_FLAG: begin
        regRdata[OVF_BIT]  = ovfFlag;
        regRdata[EDGE_BIT] = edgeFlag;
      end
      SEL_CNT:  regRdata = cntReg;
      default:  regRdata = '0;
    endcase
  end

  assign paOvfIrq  = ovfFlag  & maskReg[OVF_BIT];
  assign paEdgeIrq = edgeFlag & maskReg[EDGE_BIT];

  // R1: a counter write lands exactly
  assert_cnt_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.cntWr) |-> cntReg == $past(regWdata));

  // R3: an increment adds one
  assert_cnt_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.cntInc) && !$past(strb.cntWr)) |-> cntReg == $past(cntReg) + 1'b1);

  // R5: a wrap leaves the wrap flag set
  assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.cntInc) && !$past(strb.cntWr) && $past(cntReg) == '1) |-> ovfFlag);

  // R8: hardware set beats a same-cycle clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.cntInc) |-> edgeFlag);

  // R9: a counter write never raises the wrap flag
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.cntWr) && !$past(ovfFlag)) |-> !ovfFlag);

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 8'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              accumPin,
  input  logic              edgeFallSel,
  output logic              paOvfIrq,
  output logic              paEdgeIrq
);

  paStrobe_t strb;
  paRdSel_t  rdSel;

  pa_ctrl #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR), .CNT_ADDR(CNT_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .accumPin(accumPin), .edgeFallSel(edgeFallSel),
    .strb(strb), .rdSel(rdSel)
  );

  pa_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .paOvfIrq(paOvfIrq), .paEdgeIrq(paEdgeIrq)
  );

endmodule

// File: tb/sim_pulse_accum.sv
module sim_pulse_accum;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       accumPin = 1'b0;
  logic       edgeFallSel = 1'b0;
  logic       paOvfIrq, paEdgeIrq;

  int    nVec = 0;
  int    nBad = 0;
  bit    done = 0;
  string curReq = "R10";

  // reference model state
  int mCnt = 0;
  bit mCntKnown = 0;
  int mMask = 0;
  bit mOvf = 0, mEdge = 0;
  int pinQ[$] = '{0, 0, 0};

  always #(CLK_P/2) clk = ~clk;

  pulse_accum u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .accumPin(accumPin),
    .edgeFallSel(edgeFallSel), .paOvfIrq(paOvfIrq), .paEdgeIrq(paEdgeIrq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mOvf = 0; mEdge = 0;
      pinQ = '{0, 0, 0};
    end else begin
      bit hit;
      bit wrapped;
      hit = edgeFallSel ? (pinQ[2] == 1 && pinQ[1] == 0)
                        : (pinQ[1] == 1 && pinQ[2] == 0);
      wrapped = 0;
      if (regWe && regAddr == 8'h27) begin
        mCnt = regWdata; mCntKnown = 1;
      end else if (hit) begin
        if (mCnt == 255) wrapped = 1;
        mCnt = (mCnt + 1) % 256;
      end
      if (regWe && regAddr == 8'h24) mMask = regWdata & 8'hF3;
      if (regWe && regAddr == 8'h25) begin
        if (regWdata[5]) mOvf = 0;
        if (regWdata[4]) mEdge = 0;
      end
      if (wrapped) mOvf = 1;
      if (hit) mEdge = 1;
      pinQ.push_front(int'(accumPin));
      void'(pinQ.pop_back());
    end
  end

  function automatic int modelRead(input logic [7:0] a);
    case (a)
      8'h24:   return mMask;
      8'h25:   return (int'(mOvf) << 5) | (int'(mEdge) << 4);
      8'h27:   return mCnt;
      default: return 0;
    endcase
  endfunction

  task automatic report(input string req, input int got, input int exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rstN && !done) begin
      if (regAddr != 8'h27 || mCntKnown) report(curReq, int'(regRdata), modelRead(regAddr));
      report("R11", int'(paOvfIrq), int'(mOvf && mMask[5]));
      report("R11", int'(paEdgeIrq), int'(mEdge && mMask[4]));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      regWe = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic chkRead(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    regWe = 0; regAddr = a;
    #(CLK_P/4);
    report(req, int'(regRdata), exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); accumPin = ~accumPin;
      idle(2);
      @(negedge clk); accumPin = ~accumPin;
      idle(2);
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    // R10 reset values
    curReq = "R10";
    chkRead("R10", 8'h24, 0);
    chkRead("R10", 8'h25, 0);
    report("R11", int'(paOvfIrq), 0);
    // R1 counter write/read
    curReq = "R1";
    wr(8'h27, 8'h37);
    chkRead("R1", 8'h27, 8'h37);
    // R12 unmapped address
    curReq = "R12";
    wr(8'h26, 8'hFF);
    chkRead("R12", 8'h26, 0);
    chkRead("R12", 8'h24, 0);
    chkRead("R12", 8'h27, 8'h37);
    // R10 mask reserved bits
    curReq = "R10";
    wr(8'h24, 8'hFF);
    chkRead("R10", 8'h24, 8'hF3);
    wr(8'h24, 8'h00);
    // R3 rising edges, watched every clock
    curReq = "R3";
    wr(8'h27, 8'h10);
    @(negedge clk); regAddr = 8'h27;
    pulses(4);
    chkRead("R3", 8'h27, 8'h14);
    // R6 edge flag
    chkRead("R6", 8'h25, 8'h10);
    wr(8'h25, 8'h10);
    // R4 falling selection; pin idles high (one rising edge counted first)
    curReq = "R4";
    @(negedge clk); accumPin = 1; idle(4);
    wr(8'h25, 8'h30);
    @(negedge clk); edgeFallSel = 1; regAddr = 8'h27;
    @(negedge clk); accumPin = 0; idle(4);
    chkRead("R4", 8'h27, 8'h16);
    @(negedge clk); accumPin = 1; idle(4);
    chkRead("R4", 8'h27, 8'h16);
    chkRead("R4", 8'h25, 8'h10);
    wr(8'h25, 8'h10);
    @(negedge clk); accumPin = 0; idle(3);
    @(negedge clk); edgeFallSel = 0; idle(3);
    // R5 wrap
    curReq = "R5";
    wr(8'h27, 8'hFE);
    @(negedge clk); regAddr = 8'h25;
    pulses(2);
    chkRead("R5", 8'h27, 8'h00);
    chkRead("R5", 8'h25, 8'h30);
    // R11 interrupts follow enables
    curReq = "R11";
    wr(8'h24, 8'h20);
    report("R11", int'(paOvfIrq), 1);
    report("R11", int'(paEdgeIrq), 0);
    wr(8'h24, 8'h30);
    report("R11", int'(paEdgeIrq), 1);
    // R7 write-one-to-clear
    curReq = "R7";
    wr(8'h25, 8'h00);
    chkRead("R7", 8'h25, 8'h30);
    wr(8'h25, 8'h20);
    chkRead("R7", 8'h25, 8'h10);
    wr(8'h25, 8'h10);
    chkRead("R7", 8'h25, 8'h00);
    report("R11", int'(paOvfIrq), 0);
    // R8 clear colliding with hardware set
    curReq = "R8";
    @(negedge clk); accumPin = 1;
    @(negedge clk);
    @(negedge clk); regAddr = 8'h25; regWdata = 8'h10; regWe = 1;
    @(negedge clk); regWe = 0;
    chkRead("R8", 8'h25, 8'h10);
    wr(8'h25, 8'h30);
    @(negedge clk); accumPin = 0; idle(3);
    // R9 counter write colliding with a wrapping increment
    curReq = "R9";
    wr(8'h27, 8'hFF);
    @(negedge clk); accumPin = 1;
    @(negedge clk);
    @(negedge clk); regAddr = 8'h27; regWdata = 8'h80; regWe = 1;
    @(negedge clk); regWe = 0;
    chkRead("R9", 8'h27, 8'h80);
    chkRead("R9", 8'h25, 8'h10);
    @(negedge clk); accumPin = 0; idle(3);
    // R2 counter survives reset
    curReq = "R2";
    wr(8'h27, 8'h5A);
    @(negedge clk); rstN = 0;
    idle(3);
    @(negedge clk); rstN = 1;
    chkRead("R2", 8'h27, 8'h5A);
    chkRead("R2", 8'h24, 0);
    chkRead("R2", 8'h25, 0);
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule